// File: doc/BRIEF.md
# Interrupt Aggregator and GPIO Control Register Block

This block holds the system control registers of a companion I/O device. The host reaches them through a byte-wide synchronous port with an 8-bit offset. The block merges up to eight sub-function interrupt lines into a single host interrupt, using a status register and a mask register. It also drives sixteen general-purpose outputs from a data register and an output-enable register, and it pulses a per-pin change strobe whenever a pin's driven level moves.

The clock-control, PLL, edge-detect, level-invert and buffer-control registers take part in no logic here. They are plain storage that the host writes and reads back. Any register wider than a byte sits at consecutive offsets, with the low byte at the low offset. Each lane is written on its own.

Top module: `sysreg_irq_gpio`

## Requirements
- R1: A byte write to a 16-bit or 32-bit register changes only the addressed lane. Byte k of the register lives at base offset + k (for example, the 32-bit register at 0x9C..0x9F).
- R2: Reading offset 0x08 returns the revision value 3. Reading offset 0x09 returns 0.
- R3: The interrupt status byte (0x50), mask byte (0x52) and routing byte (0x54) can each be written and read back. The routing byte has no effect on the host interrupt.
- R4: A change on sub-interrupt line n is copied into status bit n at the next clock edge. A host write to the status byte can set or clear bits while the lines are steady. If a line changes in the same cycle as a status write, the line's value wins for that bit.
- R5: `hostIrq` is high exactly when (status AND mask) is nonzero, and it follows any change of either register.
- R6: The output data bytes sit at 0x78..0x7A and the output-enable bytes at 0x7C..0x7E; all six read back as written. Byte 0x7A and byte 0x7E are stored but drive no pin.
- R7: `gpioOut[i]` equals data bit i AND enable bit i. It takes its new value one clock after the write that changed it.
- R8: `gpioChg[i]` is high for exactly one cycle, in the same cycle that `gpioOut[i]` changes, and only for pins whose level actually changed.
- R9: The following storage registers read back what was written:
  - the 16-bit register at 0x60;
  - the three-byte groups at 0x64, 0x68, 0x6C, 0x70, 0x80, 0x84 and 0x88;
  - the 16-bit registers at 0x8C, 0x90, 0x94, 0x98, 0x9A and 0xE4;
  - the 32-bit register at 0x9C;
  - the bytes at 0xA0, 0xA1, 0xE0, 0xFC and 0xFF.
- R10: Reads of unmapped offsets return 0. Writes to unmapped offsets change no register.
- R11: After reset, every register, `rdData`, `hostIrq`, `gpioOut` and `gpioChg` are 0.
- R12: Read data appears on `rdData` one clock after a cycle with `rdEn` high, and holds in cycles without a read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Byte write strobe |
| rdEn | input | 1 | Byte read strobe |
| addr | input | 8 | Register byte offset |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Registered read data |
| subIrq | input | 8 | Sub-function interrupt levels |
| hostIrq | output | 1 | Combined host interrupt |
| gpioOut | output | 16 | Driven GPIO levels |
| gpioChg | output | 16 | One-cycle per-pin change strobe |

## Verification
The bench targets the following corner cases and the failure each one would expose:

- **Status write racing a line change.** A status write lands in the same cycle as a rising interrupt line. A design that let the host write win would lose that interrupt.
- **Clearing status under a steady line.** A status bit is cleared by the host while its line stays high. A design that re-sampled the line every cycle would re-set the bit at once.
- **Data or enable written alone.** GPIO data is written while its enable is off, and the reverse. A design that drove data without gating it by the enable would pulse change strobes on pins that never moved.
- **Lane isolation and decode holes.** One lane of the 32-bit register is rewritten, and every unmapped offset is written. A decode slip or a wide write would disturb neighbouring bytes.

// File: rtl/sysreg_pkg.sv
package sysreg_pkg;

  localparam int STORE_BYTES = 44;
  localparam int STORE_IDX_W = $clog2(STORE_BYTES);
  localparam int GP_LANE_W   = 2;

  typedef enum logic [2:0] {
    RD_ZERO,
    RD_REV,
    RD_STAT,
    RD_MASK,
    RD_ROUTE,
    RD_GPDATA,
    RD_GPEN,
    RD_STORE
  } rdSel_e;

  typedef struct packed {
    logic                   wrStat;
    logic                   wrMask;
    logic                   wrRoute;
    logic                   wrGpData;
    logic                   wrGpEn;
    logic                   wrStore;
    logic                   rdEn;
    rdSel_e                 rdSel;
    logic [GP_LANE_W-1:0]   gpLane;
    logic [STORE_IDX_W-1:0] storeIdx;
  } ctrlStrobes_t;

  typedef struct packed {
    logic                   hit;
    logic [STORE_IDX_W-1:0] idx;
  } storeMap_t;

endpackage

// File: rtl/sysreg_decode.sv
module sysreg_decode
  import sysreg_pkg::*;
#(
  parameter int GPIO_BYTES = 3
) (
  input  logic         wrEn,
  input  logic         rdEn,
  input  logic [7:0]   addr,
  output ctrlStrobes_t strb
);

  function automatic storeMap_t mapStore(input logic [7:0] a);
    storeMap_t r;
    int        grp;
    r   = '0;
    grp = -1;
    case (a[7:2])
      6'h19: grp = 0;
      6'h1A: grp = 1;
      6'h1B: grp = 2;
      6'h1C: grp = 3;
      6'h20: grp = 4;
      6'h21: grp = 5;
      6'h22: grp = 6;
      default: grp = -1;
    endcase
    if (a inside {[8'h60:8'h61]}) begin
      r = '{1'b1, STORE_IDX_W'(a - 8'h60)};
    end else if (grp >= 0 && a[1:0] != 2'b11) begin
      r = '{1'b1, STORE_IDX_W'(2 + 3 * grp + int'(a[1:0]))};
    end else if (a inside {[8'h8C:8'h8D]}) begin
      r = '{1'b1, STORE_IDX_W'(23 + int'(a[0]))};
    end else if (a inside {[8'h90:8'h91]}) begin
      r = '{1'b1, STORE_IDX_W'(25 + int'(a[0]))};
    end else if (a inside {[8'h94:8'h95]}) begin
      r = '{1'b1, STORE_IDX_W'(27 + int'(a[0]))};
    end else if (a inside {[8'h98:8'h9B]}) begin
      r = '{1'b1, STORE_IDX_W'(29 + int'(a[1:0]))};
    end else if (a inside {[8'h9C:8'h9F]}) begin
      r = '{1'b1, STORE_IDX_W'(33 + int'(a[1:0]))};
    end else if (a == 8'hA0) begin
      r = '{1'b1, STORE_IDX_W'(37)};
    end else if (a == 8'hA1) begin
      r = '{1'b1, STORE_IDX_W'(38)};
    end else if (a == 8'hE0) begin
      r = '{1'b1, STORE_IDX_W'(39)};
    end else if (a inside {[8'hE4:8'hE5]}) begin
      r = '{1'b1, STORE_IDX_W'(40 + int'(a[0]))};
    end else if (a == 8'hFC) begin
      r = '{1'b1, STORE_IDX_W'(42)};
    end else if (a == 8'hFF) begin
      r = '{1'b1, STORE_IDX_W'(43)};
    end
    return r;
  endfunction

  storeMap_t storeHit;
  logic      gpLaneOk;

  always_comb begin
    storeHit      = mapStore(addr);
    gpLaneOk      = int'(addr[1:0]) < GPIO_BYTES;
    strb          = '0;
    strb.rdEn     = rdEn;
    strb.rdSel    = RD_ZERO;
    strb.gpLane   = addr[1:0];
    strb.storeIdx = storeHit.idx;
    if (addr == 8'h08) begin
      strb.rdSel = RD_REV;
    end else if (addr == 8'h50) begin
      strb.rdSel  = RD_STAT;
      strb.wrStat = wrEn;
    end else if (addr == 8'h52) begin
      strb.rdSel  = RD_MASK;
      strb.wrMask = wrEn;
    end else if (addr == 8'h54) begin
      strb.rdSel   = RD_ROUTE;
      strb.wrRoute = wrEn;
    end else if (addr[7:2] == 6'h1E && gpLaneOk) begin
      strb.rdSel    = RD_GPDATA;
      strb.wrGpData = wrEn;
    end else if (addr[7:2] == 6'h1F && gpLaneOk) begin
      strb.rdSel  = RD_GPEN;
      strb.wrGpEn = wrEn;
    end else if (storeHit.hit) begin
      strb.rdSel   = RD_STORE;
      strb.wrStore = wrEn;
    end
  end

endmodule

// File: rtl/sysreg_datapath.sv
module sysreg_datapath
  import sysreg_pkg::*;
#(
  parameter int NUM_SUB_IRQ = 8,
  parameter int NUM_GPIO    = 16,
  parameter int GPIO_BYTES  = 3,
  parameter int REV_ID      = 3
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  ctrlStrobes_t           strb,
  input  logic [7:0]             wrData,
  input  logic [NUM_SUB_IRQ-1:0] subIrq,
  output logic [7:0]             rdData,
  output logic [7:0]             statQ,
  output logic [7:0]             maskQ,
  output logic [NUM_GPIO-1:0]    gpioOut,
  output logic [NUM_GPIO-1:0]    gpioChg
);

  logic [NUM_SUB_IRQ-1:0]      subPrevQ;
  logic [7:0]                  routeQ;
  logic [GPIO_BYTES-1:0][7:0]  gpDataQ;
  logic [GPIO_BYTES-1:0][7:0]  gpEnQ;
  logic [NUM_GPIO-1:0]         effLvl;
  logic [NUM_GPIO-1:0]         drvQ;
  logic [NUM_GPIO-1:0]         chgQ;
  logic [7:0]                  storeQ [STORE_BYTES];

  // status bits: line changes take priority over host writes
  always_ff @(posedge clk) begin
    if (!rst_n) subPrevQ <= '0;
    else        subPrevQ <= subIrq;
  end

  for (genvar k = 0; k < 8; k++) begin : g_stat
    if (k < NUM_SUB_IRQ) begin : g_line
      always_ff @(posedge clk) begin
        if (!rst_n)                         statQ[k] <= 1'b0;
        else if (subIrq[k] != subPrevQ[k])  statQ[k] <= subIrq[k];
        else if (strb.wrStat)               statQ[k] <= wrData[k];
      end
    end else begin : g_host
      always_ff @(posedge clk) begin
        if (!rst_n)           statQ[k] <= 1'b0;
        else if (strb.wrStat) statQ[k] <= wrData[k];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      maskQ  <= '0;
      routeQ <= '0;
    end else begin
      if (strb.wrMask)  maskQ  <= wrData;
      if (strb.wrRoute) routeQ <= wrData;
    end
  end

  // GPIO lanes
  for (genvar g = 0; g < GPIO_BYTES; g++) begin : g_lane
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        gpDataQ[g] <= '0;
        gpEnQ[g]   <= '0;
      end else begin
        if (strb.wrGpData && strb.gpLane == GP_LANE_W'(g)) gpDataQ[g] <= wrData;
        if (strb.wrGpEn   && strb.gpLane == GP_LANE_W'(g)) gpEnQ[g]   <= wrData;
      end
    end
  end

  for (genvar i = 0; i < NUM_GPIO; i++) begin : g_eff
    assign effLvl[i] = gpDataQ[i / 8][i % 8] & gpEnQ[i / 8][i % 8];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      drvQ <= '0;
      chgQ <= '0;
    end else begin
      drvQ <= effLvl;
      chgQ <= effLvl ^ drvQ;
    end
  end

  assign gpioOut = drvQ;
  assign gpioChg = chgQ;

  // plain storage bytes
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int j = 0; j < STORE_BYTES; j++) storeQ[j] <= '0;
    end else if (strb.wrStore) begin
      storeQ[strb.storeIdx] <= wrData;
    end
  end

  // registered read port
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdData <= '0;
    end else if (strb.rdEn) begin
      case (strb.rdSel)
        RD_REV:    rdData <= 8'(REV_ID);
        RD_STAT:   rdData <= statQ;
        RD_MASK:   rdData <= maskQ;
        RD_ROUTE:  rdData <= routeQ;
        RD_GPDATA: rdData <= gpDataQ[strb.gpLane];
        RD_GPEN:   rdData <= gpEnQ[strb.gpLane];
        RD_STORE:  rdData <= storeQ[strb.storeIdx];
        default:   rdData <= '0;
      endcase
    end
  end

endmodule

// File: rtl/sysreg_irq_gpio.sv
module sysreg_irq_gpio
  import sysreg_pkg::*;
#(
  parameter int NUM_SUB_IRQ = 8,
  parameter int NUM_GPIO    = 16,
  parameter int GPIO_BYTES  = 3,
  parameter int REV_ID      = 3
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wrEn,
  input  logic                   rdEn,
  input  logic [7:0]             addr,
  input  logic [7:0]             wrData,
  output logic [7:0]             rdData,
  input  logic [NUM_SUB_IRQ-1:0] subIrq,
  output logic                   hostIrq,
  output logic [NUM_GPIO-1:0]    gpioOut,
  output logic [NUM_GPIO-1:0]    gpioChg
);

  ctrlStrobes_t strb;
  logic [7:0]   statQ;
  logic [7:0]   maskQ;

  sysreg_decode #(.GPIO_BYTES(GPIO_BYTES)) u_decode (
    .wrEn   (wrEn),
    .rdEn   (rdEn),
    .addr   (addr),
    .strb   (strb)
  );

  sysreg_datapath #(
    .NUM_SUB_IRQ(NUM_SUB_IRQ),
    .NUM_GPIO   (NUM_GPIO),
    .GPIO_BYTES (GPIO_BYTES),
    .REV_ID     (REV_ID)
  ) u_dp (
    .clk     (clk),
    .rst_n   (rst_n),
    .strb    (strb),
    .wrData  (wrData),
    .subIrq  (subIrq),
    .rdData  (rdData),
    .statQ   (statQ),
    .maskQ   (maskQ),
    .gpioOut (gpioOut),
    .gpioChg (gpioChg)
  );

  assign hostIrq = |(statQ & maskQ);

endmodule

// File: rtl/sysreg_chk.sv
module sysreg_chk #(
  parameter int NUM_SUB_IRQ = 8,
  parameter int NUM_GPIO    = 16
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   wrEn,
  input logic                   rdEn,
  input logic [7:0]             rdData,
  input logic [NUM_SUB_IRQ-1:0] subIrq,
  input logic                   hostIrq,
  input logic [7:0]             statQ,
  input logic [7:0]             maskQ,
  input logic [NUM_GPIO-1:0]    gpioOut,
  input logic [NUM_GPIO-1:0]    gpioChg
);

  logic [NUM_SUB_IRQ-1:0] linePrev;
  logic [1:0]             upCnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      linePrev <= '0;
      upCnt    <= '0;
    end else begin
      linePrev <= subIrq;
      if (upCnt != 2'd3) upCnt <= upCnt + 2'd1;
    end
  end

  for (genvar k = 0; k < NUM_SUB_IRQ; k++) begin : g_trk
    p_stat_track_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (subIrq[k] != linePrev[k]) |=> (statQ[k] == $past(subIrq[k])));
  end

  p_mask_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (maskQ == 8'h00) |-> !hostIrq);

  p_chg_match_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (upCnt != 2'd0) |-> (gpioChg == (gpioOut ^ $past(gpioOut))));

  p_gpio_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (upCnt == 2'd3 && !$past(wrEn, 2)) |-> $stable(gpioOut));

  p_rd_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (upCnt != 2'd0 && !$past(rdEn)) |-> $stable(rdData));

endmodule

bind sysreg_irq_gpio sysreg_chk #(
  .NUM_SUB_IRQ(NUM_SUB_IRQ),
  .NUM_GPIO   (NUM_GPIO)
) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .wrEn    (wrEn),
  .rdEn    (rdEn),
  .rdData  (rdData),
  .subIrq  (subIrq),
  .hostIrq (hostIrq),
  .statQ   (statQ),
  .maskQ   (maskQ),
  .gpioOut (gpioOut),
  .gpioChg (gpioChg)
);

// File: tb/tb_sysreg_irq_gpio.sv
`timescale 1ns/1ps
module tb_sysreg_irq_gpio;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        wrEn, rdEn;
  logic [7:0]  addr, wrData, rdData;
  logic [7:0]  subIrq;
  logic        hostIrq;
  logic [15:0] gpioOut, gpioChg;

  int nChecks = 0;
  int nErrs   = 0;

  always #5 clk = ~clk;

  sysreg_irq_gpio dut (
    .clk(clk), .rst_n(rst_n), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .wrData(wrData), .rdData(rdData), .subIrq(subIrq), .hostIrq(hostIrq),
    .gpioOut(gpioOut), .gpioChg(gpioChg)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nErrs++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic doWrite(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    wrEn = 1'b1; addr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic doRead(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk);
    rdEn = 1'b1; addr = a;
    @(negedge clk);
    rdEn = 1'b0;
    d = rdData;
  endtask

  function automatic bit isStore(input logic [7:0] a);
    return (a inside {8'h60, 8'h61, 8'h8C, 8'h8D, 8'h90, 8'h91, 8'h94, 8'h95,
                      8'h98, 8'h99, 8'h9A, 8'h9B, 8'h9C, 8'h9D, 8'h9E, 8'h9F,
                      8'hA0, 8'hA1, 8'hE0, 8'hE4, 8'hE5, 8'hFC, 8'hFF}) ||
           (a[1:0] != 2'b11 && a[7:2] inside {6'h19, 6'h1A, 6'h1B, 6'h1C, 6'h20, 6'h21, 6'h22});
  endfunction

  function automatic bit isMapped(input logic [7:0] a);
    return isStore(a) || (a inside {8'h08, 8'h50, 8'h52, 8'h54,
                                    8'h78, 8'h79, 8'h7A, 8'h7C, 8'h7D, 8'h7E});
  endfunction

  // one cycle after a GPIO write returns, outputs show the change
  task automatic gpioStep(input logic [7:0] a, input logic [7:0] d,
                          input logic [15:0] expOut, input logic [15:0] expChg);
    doWrite(a, d);
    @(negedge clk);
    chk("R7 gpio level", gpioOut, expOut);
    chk("R8 change strobe", gpioChg, expChg);
    @(negedge clk);
    chk("R8 strobe one cycle", gpioChg, 16'h0);
  endtask

  task automatic t_reset();
    logic [7:0] d;
    chk("R11 rdData reset", rdData, 8'h0);
    chk("R11 hostIrq reset", hostIrq, 1'b0);
    chk("R11 gpioOut reset", gpioOut, 16'h0);
    chk("R11 gpioChg reset", gpioChg, 16'h0);
    doRead(8'h50, d); chk("R11 status reset", d, 8'h0);
    doRead(8'h9C, d); chk("R11 storage reset", d, 8'h0);
    doRead(8'h7C, d); chk("R11 enable reset", d, 8'h0);
  endtask

  task automatic t_revision();
    logic [7:0] d;
    doRead(8'h08, d); chk("R2 revision low", d, 8'h03);
    doRead(8'h09, d); chk("R2 revision high", d, 8'h00);
  endtask

  task automatic t_irq_regs();
    logic [7:0] d;
    doWrite(8'h54, 8'h3C);
    doRead(8'h54, d); chk("R3 routing readback", d, 8'h3C);
    chk("R3 routing no irq effect", hostIrq, 1'b0);
    doWrite(8'h52, 8'h05);
    doRead(8'h52, d); chk("R3 mask readback", d, 8'h05);
    doWrite(8'h50, 8'h80);
    doRead(8'h50, d); chk("R3 status readback", d, 8'h80);
    chk("R5 masked status no irq", hostIrq, 1'b0);
    doWrite(8'h50, 8'h04);
    chk("R5 status and mask irq", hostIrq, 1'b1);
    doWrite(8'h50, 8'h00);
    chk("R5 irq drops", hostIrq, 1'b0);
  endtask

  task automatic t_irq_track();
    logic [7:0] d;
    @(negedge clk); subIrq = 8'h01;
    @(negedge clk);
    chk("R5 line0 raises irq", hostIrq, 1'b1);
    doRead(8'h50, d); chk("R4 status follows line0", d, 8'h01);
    @(negedge clk); subIrq = 8'h02;
    @(negedge clk);
    chk("R5 masked line1 no irq", hostIrq, 1'b0);
    doRead(8'h50, d); chk("R4 status after swap", d, 8'h02);
    @(negedge clk); subIrq = 8'h06;
    @(negedge clk);
    chk("R5 line2 raises irq", hostIrq, 1'b1);
    doWrite(8'h50, 8'h00);
    chk("R4 host clear under steady line", hostIrq, 1'b0);
    repeat (3) @(negedge clk);
    doRead(8'h50, d); chk("R4 cleared bits stay clear", d, 8'h00);
  endtask

  task automatic t_irq_conflict();
    logic [7:0] d;
    @(negedge clk);
    subIrq = 8'h0E; wrEn = 1'b1; addr = 8'h50; wrData = 8'h00;
    @(negedge clk);
    wrEn = 1'b0;
    doRead(8'h50, d); chk("R4 line change beats write", d, 8'h08);
    @(negedge clk); subIrq = 8'h00;
    @(negedge clk);
    doRead(8'h50, d); chk("R4 falling lines clear", d, 8'h00);
  endtask

  task automatic t_gpio();
    logic [7:0] d;
    gpioStep(8'h7C, 8'hFF, 16'h0000, 16'h0000);
    gpioStep(8'h78, 8'hA5, 16'h00A5, 16'h00A5);
    gpioStep(8'h79, 8'hFF, 16'h00A5, 16'h0000);
    gpioStep(8'h7D, 8'h0F, 16'h0FA5, 16'h0F00);
    gpioStep(8'h78, 8'h3C, 16'h0F3C, 16'h0099);
    gpioStep(8'h7A, 8'hFF, 16'h0F3C, 16'h0000);
    gpioStep(8'h7E, 8'hFF, 16'h0F3C, 16'h0000);
    doRead(8'h78, d); chk("R6 data0 readback", d, 8'h3C);
    doRead(8'h79, d); chk("R6 data1 readback", d, 8'hFF);
    doRead(8'h7A, d); chk("R6 data2 held", d, 8'hFF);
    doRead(8'h7D, d); chk("R6 enable1 readback", d, 8'h0F);
    doRead(8'h7E, d); chk("R6 enable2 held", d, 8'hFF);
  endtask

  task automatic t_lanes();
    logic [7:0] d;
    doWrite(8'h9C, 8'h11); doWrite(8'h9D, 8'h22);
    doWrite(8'h9E, 8'h33); doWrite(8'h9F, 8'h44);
    doWrite(8'h9E, 8'hAB);
    doRead(8'h9C, d); chk("R1 lane0 kept", d, 8'h11);
    doRead(8'h9D, d); chk("R1 lane1 kept", d, 8'h22);
    doRead(8'h9E, d); chk("R1 lane2 rewritten", d, 8'hAB);
    doRead(8'h9F, d); chk("R1 lane3 kept", d, 8'h44);
    doWrite(8'h61, 8'h5E);
    doRead(8'h60, d); chk("R1 16-bit low kept", d, 8'h00);
    doRead(8'h61, d); chk("R1 16-bit high written", d, 8'h5E);
  endtask

  task automatic t_storage();
    logic [7:0] d;
    for (int a = 0; a < 256; a++)
      if (isStore(8'(a))) doWrite(8'(a), 8'(a) ^ 8'h5A);
    for (int a = 0; a < 256; a++)
      if (!isMapped(8'(a))) doWrite(8'(a), 8'hFF);
    for (int a = 0; a < 256; a++)
      if (isStore(8'(a))) begin
        doRead(8'(a), d);
        chk("R9 storage readback", {24'h0, d}, {24'h0, 8'(a) ^ 8'h5A});
      end
    for (int a = 0; a < 256; a++)
      if (!isMapped(8'(a))) begin
        doRead(8'(a), d);
        chk("R10 unmapped reads zero", {24'h0, d}, 32'h0);
      end
    doRead(8'h52, d); chk("R10 mask untouched", d, 8'h05);
    doRead(8'h78, d); chk("R10 gpio data untouched", d, 8'h3C);
    chk("R10 gpio pins untouched", gpioOut, 16'h0F3C);
  endtask

  task automatic t_rd_latency();
    logic [7:0] d;
    @(negedge clk);
    rdEn = 1'b1; addr = 8'h08;
    chk("R12 no data before edge", rdData == 8'h03, 1'b0);
    @(negedge clk);
    rdEn = 1'b0; addr = 8'h52;
    chk("R12 data after one clock", rdData, 8'h03);
    @(negedge clk);
    chk("R12 data holds without read", rdData, 8'h03);
    doRead(8'h52, d); chk("R12 next read", d, 8'h05);
  endtask

  initial begin
    #2000000;
    nErrs++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrs);
    $finish;
  end

  initial begin
    rst_n = 1'b0; wrEn = 1'b0; rdEn = 1'b0;
    addr = '0; wrData = '0; subIrq = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_revision();
    t_irq_regs();
    t_irq_track();
    t_irq_conflict();
    t_gpio();
    t_lanes();
    t_storage();
    t_rd_latency();
    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrs);
    $finish;
  end

endmodule